// File: doc/BRIEF.md
# Three-Channel Timer Register Interface

This block is the byte-wide host-facing register front end of a three-channel interval timer. A 2-bit address picks one of three counter data ports (addresses 0 to 2) or the control port (address 3). The block decodes control words and runs, for every channel, the byte sequencing that turns 8-bit bus writes into 16-bit count loads and 16-bit counts into 8-bit bus reads. It also handles the snapshot commands that freeze a count or a status byte until the host reads it.

On the channel side, the block pulses a load strobe with a 16-bit value and presents each channel's programmed mode and BCD flag. In return it samples each channel's live count and output level. The counting itself lives in the channel instances and is outside this block.

Top module: `tmr_regif`

## Requirements
- R1: A write to address 3 whose bits 7:6 hold 0, 1 or 2 and whose bits 5:4 are nonzero programs that channel only. Bits 5:4 set the byte access: 1 is low byte only, 2 is high byte only, 3 is low then high. Bits 3:1 set the mode and bit 0 the BCD flag. The result is visible on `chMode`/`chBcd` after the clock edge of the write.
- R2: Mode codes 6 and 7 are stored, reported and status-encoded as 2 and 3.
- R3: In low-only access, a data port write raises that channel's `chLoad` for exactly one cycle, the cycle after the write, with value {8'h00, byte}.
- R4: In high-only access, a data port write loads {byte, 8'h00} with the same timing as R3.
- R5: In low-then-high access, the first byte is held and causes no load. The second byte loads {second, first}, and the next write is again taken as a low byte.
- R6: A control write with bits 5:4 = 0 freezes the channel's live count. Later data reads return the frozen value per the channel's access: one byte (low or high) for a single-byte access, or low then high for low-then-high access. The frozen value is then released.
- R7: A count snapshot request while a count snapshot is still unread is ignored. A status snapshot request while a status snapshot is still unread is ignored.
- R8: A control write with bits 7:6 = 3 is a multi-channel snapshot. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low requests a count snapshot and bit 4 low requests a status snapshot. Unselected channels are unaffected.
- R9: The status byte holds the channel output level at the snapshot edge in bit 7, 0 in bit 6, the access code in bits 5:4, the mode in bits 3:1 and the BCD flag in bit 0.
- R10: A data port read returns a pending status first, then a pending count snapshot, and otherwise the live count.
- R11: Live reads return the low byte in low-only access and the high byte in high-only access. In low-then-high access they alternate low, high, low and so on.
- R12: A read of address 3 returns 0 and changes no sequencing. Programming a channel restarts both its read and write byte sequences at the low byte.
- R13: After reset, each channel has low-then-high access, mode 0, BCD 0, no pending snapshots and no load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Host write strobe, one cycle per byte |
| busRd | input | 1 | Host read strobe; the read's side effects occur at the clock edge |
| busAddr | input | 2 | 0 to 2 select a data port, 3 selects the control port |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte, valid while busRd is high |
| chLoad | output | 3 | Per-channel count load pulse |
| chLoadValue | output | 48 | Per-channel 16-bit load value, channel i in bits 16i+15:16i |
| chMode | output | 9 | Per-channel mode, channel i in bits 3i+2:3i |
| chBcd | output | 3 | Per-channel BCD flag |
| chLiveCount | input | 48 | Per-channel live count from the channels |
| chOut | input | 3 | Per-channel output level from the channels |

## Verification
The assertions take it for granted that the host never raises `busWr` and `busRd` in the same cycle. A snapshot command and a read of the same channel therefore never meet at one edge, and the hold properties on pending snapshots rely on that. The bench keeps the live counts and output levels steady around every command edge and changes them only between bus operations. It issues each access as a single strobe cycle followed by an idle cycle, so it never drives both strobes at once.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  localparam int NUM_CH = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  // control -> datapath strobes for one channel
  typedef struct packed {
    logic doProg;
    logic latchCnt;
    logic latchSts;
    logic wrByte;
    logic rdByte;
  } chStrobe_t;

  // codes 6 and 7 fold onto 2 and 3
  function automatic logic [MODE_W-1:0] foldMode(input logic [MODE_W-1:0] raw);
    if (raw[2] && raw[1]) return {1'b0, raw[1:0]};
    return raw;
  endfunction
endpackage

// File: rtl/tmr_regif_ctrl.sv
module tmr_regif_ctrl
  import tmr_regif_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busWr,
  input  logic                           busRd,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [BYTE_W-1:0]              busWrData,
  output chStrobe_t [NUM_CH-1:0]         strb,
  output acc_e                           cfgAcc,
  output logic [MODE_W-1:0]              cfgMode,
  output logic                           cfgBcd
);
  logic       ctlWr;
  logic [1:0] selField;
  logic       rbCmd;
  acc_e       accField;
  logic [NUM_CH-1:0] progVec;

  assign ctlWr    = busWr && (busAddr == CTL_ADDR);
  assign selField = busWrData[7:6];
  assign rbCmd    = (selField == 2'd3);
  assign accField = acc_e'(busWrData[5:4]);

  assign cfgAcc  = accField;
  assign cfgMode = foldMode(busWrData[3:1]);
  assign cfgBcd  = busWrData[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_strb
    logic      hit;
    logic      rbSel;
    chStrobe_t s;
    assign hit   = !rbCmd && (selField == 2'(i));
    assign rbSel = rbCmd && busWrData[1+i];
    always_comb begin
      s.doProg   = ctlWr && hit && (accField != ACC_NONE);
      s.latchCnt = ctlWr && ((hit && (accField == ACC_NONE)) || (rbSel && !busWrData[5]));
      s.latchSts = ctlWr && rbSel && !busWrData[4];
      s.wrByte   = busWr && (busAddr == ADDR_W'(i));
      s.rdByte   = busRd && (busAddr == ADDR_W'(i));
    end
    assign strb[i]    = s;
    assign progVec[i] = s.doProg;
  end

  // R1: a control word programs at most one channel
  assert_single_prog_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(progVec));

  // R1: host never issues a read and a write together (input assumption)
  assert_bus_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));
endmodule

// File: rtl/tmr_regif_chan.sv
module tmr_regif_chan
  import tmr_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strb,
  input  acc_e              cfgAcc,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              cfgBcd,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic [CNT_W-1:0]  liveCount,
  input  logic              outLvl,
  output logic [BYTE_W-1:0] rdByte,
  output logic              load,
  output logic [CNT_W-1:0]  loadValue,
  output logic [MODE_W-1:0] mode,
  output logic              bcd
);
  acc_e              acc;
  logic              wrHigh;
  logic              rdHigh;
  logic [BYTE_W-1:0] wrHold;
  acc_e              cntLatState;
  logic [CNT_W-1:0]  cntLat;
  logic              stsValid;
  logic [BYTE_W-1:0] stsByte;
  logic [BYTE_W-1:0] statusNow;

  assign statusNow = {outLvl, 1'b0, acc, mode, bcd};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc         <= ACC_WORD;
      mode        <= '0;
      bcd         <= 1'b0;
      wrHigh      <= 1'b0;
      rdHigh      <= 1'b0;
      wrHold      <= '0;
      cntLatState <= ACC_NONE;
      cntLat      <= '0;
      stsValid    <= 1'b0;
      stsByte     <= '0;
      load        <= 1'b0;
      loadValue   <= '0;
    end else begin
      load <= 1'b0;
      if (strb.doProg) begin
        acc    <= cfgAcc;
        mode   <= cfgMode;
        bcd    <= cfgBcd;
        wrHigh <= 1'b0;
        rdHigh <= 1'b0;
      end
      if (strb.latchCnt && (cntLatState == ACC_NONE)) begin
        cntLat      <= liveCount;
        cntLatState <= acc;
      end
      if (strb.latchSts && !stsValid) begin
        stsByte  <= statusNow;
        stsValid <= 1'b1;
      end
      if (strb.wrByte) begin
        case (acc)
          ACC_LO: begin
            loadValue <= {{BYTE_W{1'b0}}, busWrData};
            load      <= 1'b1;
          end
          ACC_HI: begin
            loadValue <= {busWrData, {BYTE_W{1'b0}}};
            load      <= 1'b1;
          end
          ACC_WORD: begin
            if (!wrHigh) begin
              wrHold <= busWrData;
              wrHigh <= 1'b1;
            end else begin
              loadValue <= {busWrData, wrHold};
              load      <= 1'b1;
              wrHigh    <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (strb.rdByte) begin
        if (stsValid) begin
          stsValid <= 1'b0;
        end else if (cntLatState != ACC_NONE) begin
          cntLatState <= (cntLatState == ACC_WORD) ? ACC_HI : ACC_NONE;
        end else if (acc == ACC_WORD) begin
          rdHigh <= !rdHigh;
        end
      end
    end
  end

  always_comb begin
    rdByte = liveCount[BYTE_W-1:0];
    if (stsValid) begin
      rdByte = stsByte;
    end else if (cntLatState != ACC_NONE) begin
      rdByte = (cntLatState == ACC_HI) ? cntLat[CNT_W-1:BYTE_W] : cntLat[BYTE_W-1:0];
    end else begin
      case (acc)
        ACC_HI:   rdByte = liveCount[CNT_W-1:BYTE_W];
        ACC_WORD: rdByte = rdHigh ? liveCount[CNT_W-1:BYTE_W] : liveCount[BYTE_W-1:0];
        default:  rdByte = liveCount[BYTE_W-1:0];
      endcase
    end
  end

  // R3: a load pulse only follows a data port write
  assert_load_after_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    load |-> $past(strb.wrByte));

  // R5: the first byte of a word write never loads
  assert_word_low_no_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrByte && acc == ACC_WORD && !wrHigh) |=> !load);

  // R2: stored mode never holds an unfolded code
  assert_mode_folded_R2: assert property (@(posedge clk) disable iff (!rstN)
    mode <= 3'd5);

  // R1: access code is never the snapshot code
  assert_acc_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    acc != ACC_NONE);

  // R7: a pending count snapshot is not overwritten
  assert_cnt_latch_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchCnt && cntLatState != ACC_NONE) |=> $stable(cntLat));

  // R7: a pending status snapshot is not overwritten
  assert_sts_latch_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchSts && stsValid) |=> $stable(stsByte));

  // R10: reading a pending status releases it and keeps the count snapshot
  assert_sts_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdByte && stsValid) |=> (!stsValid && $stable(cntLatState)));
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic [1:0]                 busAddr,
  input  logic [7:0]                 busWrData,
  output logic [7:0]                 busRdData,
  output logic [2:0]                 chLoad,
  output logic [47:0]                chLoadValue,
  output logic [8:0]                 chMode,
  output logic [2:0]                 chBcd,
  input  logic [47:0]                chLiveCount,
  input  logic [2:0]                 chOut
);
  chStrobe_t [NUM_CH-1:0] strb;
  acc_e                   cfgAcc;
  logic [MODE_W-1:0]      cfgMode;
  logic                   cfgBcd;
  logic [BYTE_W-1:0]      chRd [NUM_CH];

  tmr_regif_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busRd     (busRd),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .strb      (strb),
    .cfgAcc    (cfgAcc),
    .cfgMode   (cfgMode),
    .cfgBcd    (cfgBcd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    tmr_regif_chan u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .strb      (strb[i]),
      .cfgAcc    (cfgAcc),
      .cfgMode   (cfgMode),
      .cfgBcd    (cfgBcd),
      .busWrData (busWrData),
      .liveCount (chLiveCount[i*CNT_W +: CNT_W]),
      .outLvl    (chOut[i]),
      .rdByte    (chRd[i]),
      .load      (chLoad[i]),
      .loadValue (chLoadValue[i*CNT_W +: CNT_W]),
      .mode      (chMode[i*MODE_W +: MODE_W]),
      .bcd       (chBcd[i])
    );
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(i)) busRdData = chRd[i];
    end
  end

  // R12: the control address reads as zero
  assert_ctl_read_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == CTL_ADDR) |-> (busRdData == '0));

  // R13: no load strobe in the first cycle after reset
  assert_reset_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (chLoad == '0));
endmodule

// File: tb/tmr_regif_tb.sv
module tmr_regif_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [7:0]  busWrData = 8'd0;
  logic [7:0]  busRdData;
  logic [2:0]  chLoad;
  logic [47:0] chLoadValue;
  logic [8:0]  chMode;
  logic [2:0]  chBcd;
  logic [47:0] chLiveCount;
  logic [2:0]  chOut = 3'b000;
  logic [15:0] live [3];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0]  expRd[$];
  string       tagRd[$];
  int          expLdCh[$];
  logic [15:0] expLdVal[$];
  string       tagLd[$];

  always #10 clk = ~clk; // 50 MHz

  assign chLiveCount = {live[2], live[1], live[0]};

  tmr_regif u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .chLoad(chLoad),
    .chLoadValue(chLoadValue), .chMode(chMode), .chBcd(chBcd),
    .chLiveCount(chLiveCount), .chOut(chOut)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, logic [7:0] exp, string tag);
    expRd.push_back(exp);
    tagRd.push_back(tag);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic expectLoad(int ch, logic [15:0] v, string tag);
    expLdCh.push_back(ch);
    expLdVal.push_back(v);
    tagLd.push_back(tag);
  endtask

  task automatic setLive(int ch, logic [15:0] v);
    @(negedge clk);
    live[ch] = v;
  endtask

  // monitor: compares read bytes and load pulses against the queues
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rstN) begin
        if (busRd) begin
          if (expRd.size() == 0) begin
            check("R10", "unexpected read", 16'(busRdData), 16'hFFFF);
          end else begin
            automatic logic [7:0] e = expRd.pop_front();
            automatic string t = tagRd.pop_front();
            check(t, "read byte", 16'(busRdData), 16'(e));
          end
        end
        for (int i = 0; i < 3; i++) begin
          if (chLoad[i]) begin
            if (expLdCh.size() == 0) begin
              check("R5", "unexpected load on channel", 16'(i), 16'hFFFF);
            end else begin
              automatic int c = expLdCh.pop_front();
              automatic logic [15:0] v = expLdVal.pop_front();
              automatic string t = tagLd.pop_front();
              check(t, "load channel", 16'(i), 16'(c));
              check(t, "load value", chLoadValue[i*16 +: 16], v);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) live[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13", "chLoad after reset", 16'(chLoad), 16'h0);
    check("R13", "chMode after reset", 16'(chMode), 16'h0);
    check("R13", "chBcd after reset", 16'(chBcd), 16'h0);
    setLive(0, 16'h1234);
    busRead(0, 8'h34, "R13");
    busRead(0, 8'h12, "R11");

    // R5 word writes on channel 0, mode 2
    busWrite(3, 8'h34);
    check("R1", "ch0 mode", 16'(chMode[2:0]), 16'd2);
    busWrite(0, 8'hCD);
    expectLoad(0, 16'hABCD, "R5");
    busWrite(0, 8'hAB);
    busWrite(0, 8'h11);
    expectLoad(0, 16'h2211, "R5");
    busWrite(0, 8'h22);

    // R3 low-only on channel 1, mode code 7, BCD
    busWrite(3, 8'h5F);
    check("R2", "ch1 mode folded", 16'(chMode[5:3]), 16'd3);
    check("R1", "ch1 bcd", 16'(chBcd[1]), 16'd1);
    check("R1", "ch0 mode untouched", 16'(chMode[2:0]), 16'd2);
    expectLoad(1, 16'h005A, "R3");
    busWrite(1, 8'h5A);
    setLive(1, 16'h345A);
    busRead(1, 8'h5A, "R11");
    busRead(1, 8'h5A, "R11");

    // R4 high-only on channel 2
    busWrite(3, 8'hA0);
    expectLoad(2, 16'h7700, "R4");
    busWrite(2, 8'h77);
    setLive(2, 16'h7700);
    busRead(2, 8'h77, "R11");
    busRead(2, 8'h77, "R11");

    // R6/R7 count snapshot in word access
    setLive(0, 16'hBEEF);
    busWrite(3, 8'h00);
    setLive(0, 16'h1111);
    busWrite(3, 8'h00);
    busRead(0, 8'hEF, "R6");
    setLive(0, 16'h2233);
    busWrite(3, 8'h00);
    busRead(0, 8'hBE, "R7");
    busRead(0, 8'h33, "R11");
    busRead(0, 8'h22, "R11");
    setLive(0, 16'h4455);
    busWrite(3, 8'h00);
    setLive(0, 16'h0000);
    busRead(0, 8'h55, "R6");
    busRead(0, 8'h44, "R6");
    busRead(0, 8'h00, "R6");
    busRead(0, 8'h00, "R11");

    // R6 snapshot in low-only and high-only access
    setLive(1, 16'h0A0B);
    busWrite(3, 8'h40);
    setLive(1, 16'hFFFF);
    busRead(1, 8'h0B, "R6");
    busRead(1, 8'hFF, "R6");
    setLive(2, 16'h3C00);
    busWrite(3, 8'h80);
    setLive(2, 16'h0201);
    busRead(2, 8'h3C, "R6");
    busRead(2, 8'h02, "R6");

    // R8/R9/R10 multi-channel snapshot of channels 0 and 2
    @(negedge clk); chOut = 3'b101;
    setLive(0, 16'h6789);
    setLive(2, 16'h9A00);
    setLive(1, 16'h00C3);
    busWrite(3, 8'hCA);
    @(negedge clk); chOut = 3'b000;
    setLive(0, 16'h0102);
    setLive(2, 16'h0500);
    busRead(0, 8'hB4, "R9");
    busRead(0, 8'h89, "R10");
    busRead(0, 8'h67, "R8");
    busRead(0, 8'h02, "R10");
    busRead(0, 8'h01, "R11");
    busRead(2, 8'hA0, "R9");
    busRead(2, 8'h9A, "R8");
    busRead(2, 8'h05, "R10");
    busRead(1, 8'hC3, "R8");

    // R7 status snapshot held; R8 bit 5 high gives no count snapshot
    busWrite(3, 8'hE4);
    @(negedge clk); chOut = 3'b010;
    busWrite(3, 8'hE4);
    setLive(1, 16'h00D7);
    busRead(1, 8'h17, "R7");
    busRead(1, 8'hD7, "R8");

    // R8 count-only snapshot
    setLive(1, 16'h00AA);
    busWrite(3, 8'hD4);
    setLive(1, 16'h00BB);
    busRead(1, 8'hAA, "R8");
    busRead(1, 8'hBB, "R8");

    // R12 control read and sequence restart
    busRead(3, 8'h00, "R12");
    setLive(0, 16'h5566);
    busRead(0, 8'h66, "R12");
    busWrite(3, 8'h34);
    busRead(0, 8'h66, "R12");
    busWrite(0, 8'h99);
    busWrite(3, 8'h34);
    busWrite(0, 8'h10);
    expectLoad(0, 16'h2010, "R12");
    busWrite(0, 8'h20);

    // R2 mode code 6 and its status encoding
    busWrite(3, 8'hBC);
    check("R2", "ch2 mode folded", 16'(chMode[8:6]), 16'd2);
    check("R2", "ch2 bcd", 16'(chBcd[2]), 16'd0);
    @(negedge clk); chOut = 3'b000;
    busWrite(3, 8'hE8);
    busRead(2, 8'h34, "R2");

    repeat (3) @(negedge clk);
    check("R10", "reads left unconsumed", 16'(expRd.size()), 16'd0);
    check("R3", "loads not seen", 16'(expLdCh.size()), 16'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule